// File: doc/BRIEF.md
# Clock Divider and Power Mode Controller

This block turns the free-running oscillator into two single-cycle clock enables, one for the processor core and one for the peripherals. Software picks a division ratio: one of four fast settings (1, 2, 4 or 8 oscillator cycles per machine cycle) or one of two slow settings (256 or 1024). The divider restarts its count only at a pulse boundary, so a new ratio never shortens the interval already under way.

The same control write also moves the block into one of two low-power modes. In idle the core enable is held low and the program counter is frozen, while the peripheral enable keeps pulsing, so timers, the watchdog and the serial logic go on working. Any pending, enabled interrupt ends idle. In stop both enables are held low and the divider freezes. Only an external interrupt line, passed through a synchronizer, ends stop. On wake-up the mode returns to run on its own, and the ratio chosen before the low-power mode stays in force.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset the ratio field reads 0 (divide by 1) and the mode field reads 0 (run). pc_hold_o is low and core_en_o pulses on every oscillator cycle.
- R2: Ratio codes 0, 1, 2 and 3 space enable pulses 1, 2, 4 and 8 oscillator cycles apart.
- R3: Ratio code 4 spaces pulses 256 cycles apart and code 5 spaces them 1024 cycles apart. In both cases the core keeps running.
- R4: A write with ratio code 6 or 7 leaves the ratio field unchanged. The mode field of that write still takes effect.
- R5: The divider picks up a new ratio only at the next enable pulse. The interval in progress completes at its old length, and the first interval after that pulse uses the new length.
- R6: The mode field is encoded 0 = run, 1 = idle, 2 = stop, and code 3 is taken as run. A write takes effect only while in run. Writes made in idle or stop have no effect on either field.
- R7: In idle, core_en_o stays low, pc_hold_o is high, and periph_en_o keeps pulsing at the selected ratio.
- R8: In idle, a high irq_pend_i or any synchronized external line returns the mode to run on the next edge. The ratio field keeps its earlier value.
- R9: In stop, both core_en_o and periph_en_o stay low and the divider count is frozen. pc_hold_o is high.
- R10: Stop ends only on an external line, after SYNC_STAGES synchronizer flops plus one edge. irq_pend_i alone never ends stop.
- R11: mode_o and ratio_o report the current contents of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_ratio_i | input | 3 | Division ratio code to write |
| cfg_mode_i | input | 2 | Power mode code to write |
| irq_pend_i | input | 1 | Some interrupt is pending and enabled |
| ext_irq_i | input | EXT_W | Asynchronous external interrupt lines |
| core_en_o | output | 1 | Core clock enable, one cycle wide |
| periph_en_o | output | 1 | Peripheral clock enable, one cycle wide |
| pc_hold_o | output | 1 | Program counter hold |
| mode_o | output | 2 | Current power mode |
| ratio_o | output | 3 | Current ratio code |

## Verification
A ratio write can land in the same cycle as a divider pulse, or partway through a slow interval. The bench measures the gap to the following pulse in both cases and expects the old length first and the new length after it. A wake-up can also coincide with a peripheral pulse in idle, or with a frozen count in stop. The random phase fires interrupts and external lines at arbitrary points of long intervals. A per-cycle reference model then judges that the core enable reappears only at the next pulse boundary and that no pulse comes out short.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
  localparam int unsigned DIV_MED  = 256;
  localparam int unsigned DIV_SLOW = 1024;
  localparam int unsigned CNT_W    = $clog2(DIV_SLOW);
  localparam int unsigned RATIO_W  = 3;
  localparam logic [RATIO_W-1:0] RATIO_MAX = 3'd5;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_STOP = 2'd2
  } pwr_mode_e;

  function automatic logic [CNT_W-1:0] reload_of(input logic [RATIO_W-1:0] code);
    logic [CNT_W-1:0] v;
    case (code)
      3'd0:    v = CNT_W'(0);
      3'd1:    v = CNT_W'(1);
      3'd2:    v = CNT_W'(3);
      3'd3:    v = CNT_W'(7);
      3'd4:    v = CNT_W'(DIV_MED - 1);
      default: v = CNT_W'(DIV_SLOW - 1);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/clk_pwr_wake.sv
module clk_pwr_wake #(
  parameter int unsigned EXT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EXT_W-1:0] ext_irq_i,
  output logic             ext_wake_o
);
  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign ext_wake_o = |ext_irq_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0][EXT_W-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= '0;
        end else begin
          sync_q[0] <= ext_irq_i;
          for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
      end
      assign ext_wake_o = |sync_q[SYNC_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/clk_pwr_div.sv
module clk_pwr_div
  import clk_pwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               run_i,
  output logic               tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick_o  = run_i && at_zero;

  // reload only at a boundary: a new ratio never cuts an interval short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (run_i) begin
      if (at_zero)     cnt_q <= reload_of(ratio_i);
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/clk_pwr_mode.sv
module clk_pwr_mode
  import clk_pwr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic               irq_pend_i,
  input  logic               ext_wake_i,
  output pwr_mode_e          mode_o,
  output logic [RATIO_W-1:0] ratio_o
);
  pwr_mode_e          mode_q, mode_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;

  always_comb begin
    mode_d  = mode_q;
    ratio_d = ratio_q;
    case (mode_q)
      MODE_RUN: begin
        if (we_i) begin
          if (cfg_ratio_i <= RATIO_MAX) ratio_d = cfg_ratio_i;
          case (cfg_mode_i)
            2'd1:    mode_d = MODE_IDLE;
            2'd2:    mode_d = MODE_STOP;
            default: mode_d = MODE_RUN;
          endcase
        end
      end
      MODE_IDLE: if (irq_pend_i || ext_wake_i) mode_d = MODE_RUN;
      MODE_STOP: if (ext_wake_i) mode_d = MODE_RUN;
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RUN;
      ratio_q <= '0;
    end else begin
      mode_q  <= mode_d;
      ratio_q <= ratio_d;
    end
  end

  assign mode_o  = mode_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clk_pwr_pkg::*;
#(
  parameter int unsigned EXT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_ratio_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             irq_pend_i,
  input  logic [EXT_W-1:0] ext_irq_i,
  output logic             core_en_o,
  output logic             periph_en_o,
  output logic             pc_hold_o,
  output logic [1:0]       mode_o,
  output logic [2:0]       ratio_o
);
  pwr_mode_e          mode;
  logic [RATIO_W-1:0] ratio;
  logic               ext_wake;
  logic               tick;

  clk_pwr_wake #(.EXT_W(EXT_W), .SYNC_STAGES(SYNC_STAGES)) wake_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_irq_i  (ext_irq_i),
    .ext_wake_o (ext_wake)
  );

  clk_pwr_mode mode_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .cfg_ratio_i (cfg_ratio_i),
    .cfg_mode_i  (cfg_mode_i),
    .irq_pend_i  (irq_pend_i),
    .ext_wake_i  (ext_wake),
    .mode_o      (mode),
    .ratio_o     (ratio)
  );

  clk_pwr_div div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ratio_i (ratio),
    .run_i   (mode != MODE_STOP),
    .tick_o  (tick)
  );

  assign periph_en_o = tick;
  assign core_en_o   = tick && (mode == MODE_RUN);
  assign pc_hold_o   = (mode != MODE_RUN);
  assign mode_o      = mode;
  assign ratio_o     = ratio;
endmodule

// File: rtl/clk_pwr_ctrl_chk.sv
module clk_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [2:0] cfg_ratio_i,
  input logic       irq_pend_i,
  input logic       ext_wake_i,
  input logic       core_en_i,
  input logic       periph_en_i,
  input logic       pc_hold_i,
  input logic [1:0] mode_i,
  input logic [2:0] ratio_i
);
  a_r7_idle_no_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |-> (!core_en_i && pc_hold_i));

  a_r9_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |-> (!core_en_i && !periph_en_i));

  a_r7_core_needs_periph: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_en_i |-> periph_en_i);

  a_r4_bad_ratio_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && mode_i == 2'd0 && cfg_ratio_i > 3'd5) |=> $stable(ratio_i));

  a_r6_lowpower_ratio_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0) |=> $stable(ratio_i));

  a_r10_stop_needs_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && !ext_wake_i) |=> (mode_i == 2'd2));

  a_r8_idle_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && (irq_pend_i || ext_wake_i)) |=> (mode_i == 2'd0));
endmodule

bind clk_pwr_ctrl clk_pwr_ctrl_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_ratio_i (cfg_ratio_i),
  .irq_pend_i  (irq_pend_i),
  .ext_wake_i  (ext_wake),
  .core_en_i   (core_en_o),
  .periph_en_i (periph_en_o),
  .pc_hold_i   (pc_hold_o),
  .mode_i      (mode_o),
  .ratio_i     (ratio_o)
);

// File: tb/clk_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_pwr_ctrl_tb_top;
  localparam int EXT_W = 4;
  localparam int SYNC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] cfg_ratio = '0;
  logic [1:0] cfg_mode = '0;
  logic irq = 1'b0;
  logic [EXT_W-1:0] ext = '0;
  logic core_en, periph_en, pc_hold;
  logic [1:0] mode;
  logic [2:0] ratio;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_mode, m_ratio, m_left;
  logic [SYNC-1:0][EXT_W-1:0] m_sync;
  bit last_core, last_per;

  always #2.5 clk = ~clk;

  clk_pwr_ctrl #(.EXT_W(EXT_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_ratio_i(cfg_ratio),
    .cfg_mode_i(cfg_mode), .irq_pend_i(irq), .ext_irq_i(ext),
    .core_en_o(core_en), .periph_en_o(periph_en), .pc_hold_o(pc_hold),
    .mode_o(mode), .ratio_o(ratio)
  );

  function automatic int div_len(input int code);
    if (code < 4) return 1 << code;
    if (code == 4) return 256;
    return 1024;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit e_tick;
    e_tick = (m_left == 0) && (m_mode != 2);
    chk("R2 R3 R7 core_en", int'(core_en), int'(e_tick && m_mode == 0));
    chk("R7 R9 periph_en", int'(periph_en), int'(e_tick));
    chk("R6 pc_hold", int'(pc_hold), int'(m_mode != 0));
    chk("R11 mode", int'(mode), m_mode);
    chk("R11 ratio", int'(ratio), m_ratio);
    last_core = core_en;
    last_per  = periph_en;
  endtask

  // one oscillator cycle: check at negedge, drive, advance model, cross posedge
  task automatic step(input bit w, input int r, input int md, input bit ip,
                      input logic [EXT_W-1:0] ex);
    bit wake_ext;
    compare_all();
    we = w; cfg_ratio = 3'(r); cfg_mode = 2'(md); irq = ip; ext = ex;
    wake_ext = |m_sync[SYNC-1];
    if (m_mode != 2) begin
      if (m_left == 0) m_left = div_len(m_ratio) - 1;
      else m_left--;
    end
    case (m_mode)
      0: if (w) begin
           if (r <= 5) m_ratio = r;
           m_mode = (md == 1 || md == 2) ? md : 0;
         end
      1: if (ip || wake_ext) m_mode = 0;
      default: if (wake_ext) m_mode = 0;
    endcase
    for (int i = SYNC - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
    m_sync[0] = ex;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_step();
    step(0, 0, 0, 0, '0);
  endtask

  task automatic run_gap(input int wr_at, input int wr_ratio, output int gap);
    gap = 0;
    do begin
      gap++;
      step(gap == wr_at, wr_ratio, 0, 0, '0);
    end while (!last_core && gap < 5000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int g, np, nc;
    void'($urandom(32'h5eed_0042));
    m_mode = 0; m_ratio = 0; m_left = 0; m_sync = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 ratio", int'(ratio), 0);
    chk("R1 mode", int'(mode), 0);
    chk("R1 pc_hold", int'(pc_hold), 0);
    chk("R1 core_en", int'(core_en), 1);
    repeat (3) idle_step();
    chk("R1 core every cycle", int'(last_core), 1);

    // R3/R5 slow ratios and boundary-aligned changes
    step(1, 5, 0, 0, '0);
    run_gap(0, 0, g); chk("R5 first gap after write", g, 1);
    run_gap(0, 0, g); chk("R3 gap /1024", g, 1024);
    run_gap(10, 1, g); chk("R5 old interval kept", g, 1024);
    run_gap(0, 0, g); chk("R2 R5 gap /2", g, 2);
    run_gap(1, 4, g); chk("R5 gap before /256", g, 2);
    run_gap(0, 0, g); chk("R3 gap /256", g, 256);
    run_gap(1, 3, g); chk("R5 gap before /8", g, 256);
    run_gap(0, 0, g); chk("R2 gap /8", g, 8);
    run_gap(1, 7, g); chk("R4 gap after bad code", g, 8);
    chk("R4 ratio unchanged", int'(ratio), 3);
    run_gap(0, 0, g); chk("R4 gap still /8", g, 8);
    run_gap(1, 2, g); run_gap(0, 0, g); chk("R2 gap /4", g, 4);
    run_gap(1, 3, g); run_gap(0, 0, g);

    // R7/R8 idle: periph keeps pulsing, interrupt wakes
    step(1, 3, 1, 0, '0);
    np = 0; nc = 0;
    for (int i = 0; i < 16; i++) begin
      idle_step();
      np += int'(last_per); nc += int'(last_core);
    end
    chk("R7 periph pulses in idle", np, 2);
    chk("R7 core pulses in idle", nc, 0);
    chk("R7 pc_hold idle", int'(pc_hold), 1);
    step(1, 0, 0, 0, '0);
    chk("R6 write ignored in idle ratio", int'(ratio), 3);
    chk("R6 write ignored in idle mode", int'(mode), 1);
    step(0, 0, 0, 1, '0);
    chk("R8 idle wake", int'(mode), 0);
    chk("R8 ratio kept", int'(ratio), 3);

    // R9/R10 stop: no pulses, irq ignored, ext wakes after sync
    step(1, 3, 2, 0, '0);
    np = 0;
    for (int i = 0; i < 20; i++) begin
      step(0, 0, 0, 1, '0);
      np += int'(last_per);
    end
    chk("R9 no pulses in stop", np, 0);
    chk("R10 irq ignored in stop", int'(mode), 2);
    step(0, 0, 0, 0, 4'b0100);
    idle_step();
    chk("R10 still stopped in sync", int'(mode), 2);
    idle_step();
    chk("R10 ext wake", int'(mode), 0);
    chk("R8 ratio kept after stop", int'(ratio), 3);

    // R6 code 3 taken as run
    step(1, 1, 3, 0, '0);
    chk("R6 mode code 3 is run", int'(mode), 0);
    chk("R6 ratio written", int'(ratio), 1);

    // random phase, per-cycle reference comparison
    for (int n = 0; n < 60000; n++) begin
      bit w, ip;
      int r, md;
      logic [EXT_W-1:0] ex;
      w  = ($urandom % 40) == 0;
      r  = ($urandom % 8 == 0) ? 5 : ($urandom % 8);
      md = $urandom % 4;
      ip = ($urandom % 150) == 0;
      ex = (($urandom % 400) == 0) ? EXT_W'(1 << ($urandom % EXT_W)) : '0;
      step(w, r, md, ip, ex);
    end
    compare_all();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule